// File: doc/BRIEF.md
# Preempting Priority Lane Arbiter

This block decides, cycle by cycle, which of several virtual lanes places a flit on a shared output link. Every lane presents the head of its own flit queue, with a start-of-packet and an end-of-packet marker on each flit. Each lane has a fixed priority equal to its index, so with the default four lanes, lane 3 ranks highest. When the arbiter takes a flit, it pulses that lane's pop strobe. One cycle later the flit leaves on a single output stream, tagged with its lane number so that a receiver can separate interleaved packets again.

Packets are not atomic. A packet in flight on a lower lane can be suspended at any flit boundary when a higher lane presents a start-of-packet flit. The higher packet then runs to its end, and the suspended packet continues from the flit where it stopped. Suspension can nest to any depth, and suspended packets resume in last-in, first-out order. A start-of-packet flit on a lane that is not above the lane in flight waits until every packet above it has ended. If the lane in flight has no flit ready, the link idles for that cycle. Credit accounting and the queue memories sit outside the block.

The open-packet tracker is the state machine. Its states are ST_IDLE (no packet open), ST_OPEN (one packet open) and ST_NESTED (two or more open, one of them suspending the others). Its transitions are:
- T_START: ST_IDLE to ST_OPEN, when a multi-flit packet begins.
- T_PREEMPT: ST_OPEN to ST_NESTED, when a higher lane suspends the open packet.
- T_UNWIND: ST_NESTED to ST_OPEN, when the packet count drops back to one.
- T_FINISH: ST_OPEN to ST_IDLE, when the last open packet ends.

Top module: `vl_preempt_arb`

## Requirements
- R1: While reset is asserted, no pop strobe is raised and out_valid is low.
- R2: A flit popped in cycle t appears in cycle t+1 with out_valid high, carrying out_lane equal to the popped lane index and the same data, start and end markers.
- R3: When no packet is open, the highest-indexed lane whose head flit is valid and marked start is popped.
- R4: While a packet is open, a start-marked head flit on a lane with a higher index than every open lane is popped at once, suspending the open packet.
- R5: A start-marked head flit on a lane whose index is not above the highest open lane is not popped while that packet is open.
- R6: When no packet start qualifies, the highest-indexed open lane pops its next valid flit. After a packet ends, the next lower open lane resumes.
- R7: Suspension nests, and suspended packets complete in last-in, first-out order.
- R8: If the highest open lane has no valid flit and no higher start is waiting, nothing is popped in that cycle. Lower lanes do not advance.
- R9: A flit marked both start and end is a complete packet. It leaves no packet open.
- R10: At most one lane is popped per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | NUM_LANES | Head flit present, one bit per lane |
| in_sop | input | NUM_LANES | Head flit starts a packet |
| in_eop | input | NUM_LANES | Head flit ends a packet |
| in_data | input | NUM_LANES*FLIT_W | Head flit payloads, lane i at bits i*FLIT_W upward |
| in_ready | output | NUM_LANES | Pop strobe, one-hot or zero |
| out_valid | output | 1 | Output flit present |
| out_sop | output | 1 | Output flit starts a packet |
| out_eop | output | 1 | Output flit ends a packet |
| out_lane | output | LANE_W | Lane index of the output flit |
| out_data | output | FLIT_W | Output flit payload |

## Verification
The bench runs a reference model that keeps an explicit stack of open packets. It drives the arbiter through four kinds of traffic:
- A sweep over every pair of a lower and a higher lane, with the higher start arriving at each offset from before the lower packet through past its end. This separates preemption (R4) from plain start order (R3) and from resumption (R6).
- Back-to-back packets on one lane, and lower starts arriving under an open high packet. These show whether same-priority and lower-priority starts wait (R5).
- A four-deep nest that ends with single-flit packets. This tests last-in, first-out unwinding (R7, R9).
- Packets with gaps between flits. These show that an empty active lane causes idle cycles rather than letting a lower lane through (R8).

// File: rtl/vl_arb_pkg.sv
package vl_arb_pkg;

    // Occupancy of the open-packet set
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_NESTED = 2'd2
    } open_state_e;

endpackage

// File: rtl/vl_prio_pick.sv
module vl_prio_pick #(
    parameter int NUM_LANES = 4,
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic [NUM_LANES-1:0] req,
    output logic                 found,
    output logic [LANE_W-1:0]    idx
);

    // Highest set index wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_LANES - 1; i >= 0; i--) begin
            if (req[i] && !found) begin
                found = 1'b1;
                idx   = LANE_W'(i);
            end
        end
    end

endmodule

// File: rtl/vl_open_tracker.sv
module vl_open_tracker
    import vl_arb_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] pop_vec,
    input  logic [NUM_LANES-1:0] sop_vec,
    input  logic [NUM_LANES-1:0] eop_vec,
    output logic [NUM_LANES-1:0] open_vec,
    output open_state_e          state
);

    logic [NUM_LANES-1:0] open_nx;
    open_state_e          state_nx;
    int                   open_cnt_nx;

    // Next open set: an end closes, a start without end opens
    always_comb begin
        open_nx = open_vec;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (pop_vec[i]) begin
                if (eop_vec[i]) begin
                    open_nx[i] = 1'b0;
                end else if (sop_vec[i]) begin
                    open_nx[i] = 1'b1;
                end
            end
        end
        open_cnt_nx = $countones(open_nx);
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (open_cnt_nx != 0) state_nx = ST_OPEN;         // T_START
            end
            ST_OPEN: begin
                if (open_cnt_nx == 0)      state_nx = ST_IDLE;    // T_FINISH
                else if (open_cnt_nx > 1)  state_nx = ST_NESTED;  // T_PREEMPT
            end
            ST_NESTED: begin
                if (open_cnt_nx <= 1)      state_nx = ST_OPEN;    // T_UNWIND
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            open_vec <= '0;
        end else begin
            state    <= state_nx;
            open_vec <= open_nx;
        end
    end

    // R10: a single pop per cycle
    a_r10_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_vec));

    // R9: a complete single-flit packet leaves the open count unchanged
    a_r9_single_flit_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pop_vec & sop_vec & eop_vec & ~open_vec))
        |=> ($countones(open_vec) == $past($countones(open_vec))));

    // R7: the nested state means at least two packets are open
    a_r7_nested_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NESTED) |-> ($countones(open_vec) >= 2));

endmodule

// File: rtl/vl_preempt_arb.sv
module vl_preempt_arb
    import vl_arb_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int FLIT_W    = 16,
    localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          in_valid,
    input  logic [NUM_LANES-1:0]          in_sop,
    input  logic [NUM_LANES-1:0]          in_eop,
    input  logic [NUM_LANES*FLIT_W-1:0]   in_data,
    output logic [NUM_LANES-1:0]          in_ready,
    output logic                          out_valid,
    output logic                          out_sop,
    output logic                          out_eop,
    output logic [LANE_W-1:0]             out_lane,
    output logic [FLIT_W-1:0]             out_data
);

    logic [NUM_LANES-1:0] open_vec;
    open_state_e          ostate;
    logic                 owner_found;
    logic [LANE_W-1:0]    owner_idx;
    logic [NUM_LANES-1:0] above_owner;
    logic [NUM_LANES-1:0] start_req;
    logic                 start_found;
    logic [LANE_W-1:0]    start_idx;
    logic                 pick_any;
    logic [LANE_W-1:0]    sel_idx;

    // Active packet: the highest open lane
    vl_prio_pick #(.NUM_LANES(NUM_LANES)) u_owner (
        .req   (open_vec),
        .found (owner_found),
        .idx   (owner_idx)
    );

    // Lanes ranking above the active packet
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_above
        assign above_owner[g] = !owner_found || (LANE_W'(g) > owner_idx);
    end

    assign start_req = in_valid & in_sop & ~open_vec & above_owner;

    vl_prio_pick #(.NUM_LANES(NUM_LANES)) u_start (
        .req   (start_req),
        .found (start_found),
        .idx   (start_idx)
    );

    // Selection: a qualifying start preempts, else the active packet continues
    always_comb begin
        pick_any = 1'b0;
        sel_idx  = start_idx;
        if (!rst_n) begin
            pick_any = 1'b0;
        end else if (start_found) begin
            pick_any = 1'b1;
        end else if ((ostate != ST_IDLE) && in_valid[owner_idx]) begin
            pick_any = 1'b1;
            sel_idx  = owner_idx;
        end
        in_ready = pick_any ? (NUM_LANES'(1) << sel_idx) : '0;
    end

    vl_open_tracker #(.NUM_LANES(NUM_LANES)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_vec  (in_ready),
        .sop_vec  (in_sop),
        .eop_vec  (in_eop),
        .open_vec (open_vec),
        .state    (ostate)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_lane  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= pick_any;
            if (pick_any) begin
                out_sop  <= in_sop[sel_idx];
                out_eop  <= in_eop[sel_idx];
                out_lane <= sel_idx;
                out_data <= in_data[sel_idx*FLIT_W +: FLIT_W];
            end
        end
    end

    // R2: output follows a pop by one cycle
    a_r2_out_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_ready) |=> out_valid);

    a_r2_no_pop_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready == '0) |=> !out_valid);

    // R5: a new packet only starts above every open lane
    a_r5_start_above_open: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_any && in_sop[sel_idx] && !open_vec[sel_idx])
        |-> ((open_vec >> sel_idx) == '0));

    // R6: a continuation flit comes from the highest open lane
    a_r6_continue_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_any && open_vec[sel_idx])
        |-> ((open_vec >> sel_idx) == NUM_LANES'(1)));

endmodule

// File: tb/tb_vl_preempt_arb.sv
module tb_vl_preempt_arb;

    localparam int N  = 4;
    localparam int W  = 16;
    localparam int LW = 2;
    localparam int QD = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   in_valid, in_sop, in_eop, in_ready;
    logic [N*W-1:0] in_data;
    logic           out_valid, out_sop, out_eop;
    logic [LW-1:0]  out_lane;
    logic [W-1:0]   out_data;

    vl_preempt_arb #(.NUM_LANES(N), .FLIT_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_lane(out_lane), .out_data(out_data)
    );

    logic [W-1:0] qd [N][QD];
    logic         qs [N][QD];
    logic         qe [N][QD];
    int           qg [N][QD];
    int           head [N];
    int           tail [N];
    int           cyc, n_chk, n_fail, pkt_no, sp;
    int           stk [8];
    bit           done;
    logic         exp_v, exp_s, exp_e;
    logic [LW-1:0] exp_l;
    logic [W-1:0]  exp_d;
    logic [N-1:0]  pend;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic add_pkt(input int lane, input int len, input int start, input int gap);
        for (int k = 0; k < len; k++) begin
            qd[lane][tail[lane]] = {4'(lane), 4'(pkt_no), 8'(k)};
            qs[lane][tail[lane]] = (k == 0);
            qe[lane][tail[lane]] = (k == len - 1);
            qg[lane][tail[lane]] = start + k * gap;
            tail[lane]++;
        end
        pkt_no++;
    endtask

    task automatic drive();
        for (int l = 0; l < N; l++) begin
            if (head[l] < tail[l] && cyc >= qg[l][head[l]]) begin
                in_valid[l]       = 1'b1;
                in_sop[l]         = qs[l][head[l]];
                in_eop[l]         = qe[l][head[l]];
                in_data[l*W +: W] = qd[l][head[l]];
            end else begin
                in_valid[l]       = 1'b0;
                in_sop[l]         = 1'b0;
                in_eop[l]         = 1'b0;
                in_data[l*W +: W] = '0;
            end
        end
    endtask

    function automatic bit in_stack(input int j);
        for (int s = 0; s < sp; s++) if (stk[s] == j) return 1'b1;
        return 1'b0;
    endfunction

    // Reference: explicit stack of open packets
    task automatic model_step();
        int pick;
        bit fresh;
        string tag;
        logic [N-1:0] exp_rdy;
        pick  = -1;
        fresh = 1'b0;
        tag   = "R3";
        for (int j = N - 1; j >= 0; j--) begin
            if (pick < 0 && in_valid[j] && in_sop[j] && !in_stack(j) &&
                (sp == 0 || j > stk[sp-1])) pick = j;
        end
        if (pick >= 0) begin
            fresh = 1'b1;
            if (in_eop[pick])  tag = "R9";
            else if (sp == 0)  tag = "R3";
            else if (sp >= 2)  tag = "R7";
            else               tag = "R4";
            if (!in_eop[pick]) begin
                stk[sp] = pick;
                sp++;
            end
        end else if (sp > 0) begin
            if (in_valid[stk[sp-1]]) begin
                pick = stk[sp-1];
                tag  = (sp >= 2) ? "R7" : "R6";
                if (in_eop[pick]) sp--;
            end else begin
                tag = "R8";
            end
        end
        if (!fresh) begin
            for (int j = 0; j < N; j++)
                if (in_valid[j] && in_sop[j] && !in_stack(j) && j != pick) tag = "R5";
        end
        exp_rdy = (pick >= 0) ? (N'(1) << pick) : '0;
        check(in_ready == exp_rdy, tag, "in_ready", in_ready, exp_rdy);
        check($countones(in_ready) <= 1, "R10", "pops per cycle", $countones(in_ready), 1);
        exp_v = (pick >= 0);
        if (pick >= 0) begin
            exp_l = LW'(pick);
            exp_d = in_data[pick*W +: W];
            exp_s = in_sop[pick];
            exp_e = in_eop[pick];
        end
        pend = exp_rdy;
    endtask

    task automatic cycle_step();
        @(negedge clk);
        for (int l = 0; l < N; l++) if (pend[l]) head[l]++;
        pend = '0;
        check(out_valid == exp_v, "R2", "out_valid", out_valid, exp_v);
        if (exp_v) begin
            check(out_lane == exp_l, "R2", "out_lane", out_lane, exp_l);
            check(out_data == exp_d, "R2", "out_data", out_data, exp_d);
            check({out_sop, out_eop} == {exp_s, exp_e}, "R2", "markers",
                  {out_sop, out_eop}, {exp_s, exp_e});
        end
        drive();
        #1;
        model_step();
        cyc++;
    endtask

    task automatic run_scen();
        bit busy;
        int guard;
        cyc   = 0;
        guard = 0;
        busy  = 1'b1;
        while (busy && guard < 300) begin
            cycle_step();
            guard++;
            busy = (sp != 0);
            for (int l = 0; l < N; l++) if (head[l] + (pend[l] ? 1 : 0) < tail[l]) busy = 1'b1;
        end
        check(!busy, "R6", "scenario drained", busy, 0);
        cycle_step();
        cycle_step();
        for (int l = 0; l < N; l++) begin
            head[l] = 0;
            tail[l] = 0;
        end
        sp = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        n_chk = 0; n_fail = 0; pkt_no = 0; sp = 0; cyc = 0; done = 1'b0;
        pend = '0; exp_v = 1'b0; exp_s = 1'b0; exp_e = 1'b0; exp_l = '0; exp_d = '0;
        for (int l = 0; l < N; l++) begin head[l] = 0; tail[l] = 0; end
        in_valid = '0; in_sop = '0; in_eop = '0; in_data = '0;

        // R1: reset holds everything quiet even with a start waiting
        @(negedge clk);
        in_valid = 4'b1001; in_sop = 4'b1001; in_eop = '0;
        #1;
        check(in_ready == '0, "R1", "in_ready in reset", in_ready, 0);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after edge in reset", out_valid, 0);
        in_valid = '0; in_sop = '0;
        rst_n = 1'b1;

        // R4 / R6: every lower/higher pair, every arrival offset
        for (int lo = 0; lo < N - 1; lo++) begin
            for (int hi = lo + 1; hi < N; hi++) begin
                for (int d = 0; d < 6; d++) begin
                    add_pkt(lo, 5, 0, 0);
                    add_pkt(hi, 2, d, 0);
                    run_scen();
                end
            end
        end

        // R5: same lane back to back, lower starts held off
        add_pkt(2, 3, 0, 0);
        add_pkt(2, 2, 0, 0);
        add_pkt(1, 2, 0, 0);
        add_pkt(0, 1, 1, 0);
        run_scen();
        add_pkt(3, 4, 0, 0);
        add_pkt(0, 2, 1, 0);
        add_pkt(1, 1, 2, 0);
        run_scen();

        // R7 / R9: four-deep nest with single-flit packets
        add_pkt(0, 6, 0, 0);
        add_pkt(1, 4, 2, 0);
        add_pkt(2, 3, 3, 0);
        add_pkt(3, 1, 4, 0);
        add_pkt(3, 2, 5, 0);
        run_scen();
        add_pkt(2, 1, 0, 0);
        add_pkt(1, 1, 0, 0);
        add_pkt(0, 1, 0, 0);
        run_scen();

        // R8: gaps inside the active packet idle the link
        add_pkt(1, 3, 0, 3);
        add_pkt(0, 2, 0, 0);
        add_pkt(2, 2, 4, 0);
        run_scen();
        add_pkt(0, 4, 0, 4);
        add_pkt(2, 2, 1, 0);
        run_scen();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule